// File: doc/BRIEF.md
# Auto-Increment Register Pointer and Configuration Bank

This block holds the thirteen byte-wide configuration registers of a four-channel LED dimming controller and sits behind a byte-level serial slave front end. The front end has already handled bit timing and address matching. It hands over whole received bytes, asks for bytes to transmit, and reports transaction starts and STOP conditions. After each start, the first byte written is a control byte. This byte loads a register pointer and selects how the pointer steps. Every later byte is written to, or read from, the register under the pointer, and the pointer then moves on.

The pointer can step in one of four wrap windows: the whole bank, the four channel duty registers, the two group registers, or duty plus group together. A pointer that begins outside its window climbs to the top of the bank, wraps to zero, and then enters the window. The registers that shape the LED outputs (indices 2 to 8) are held twice, as a shadow copy that the bus writes and an active copy that drives the outputs. A mode bit selects when the shadow is copied to the active copy. With the bit clear, all of them change together at STOP. With the bit set, each one changes on the acknowledged byte that wrote it. This lets several controllers on one bus switch their outputs at the same time.

Top module: `ledcfg_bank`

## Requirements
- R1: The first byte written after `txn_begin_i` is a control byte. Bits [3:0] load the pointer, bits [7:5] load the step mode, and bit 4 is ignored. A control byte with pointer 0h–Ch is acknowledged (`byte_ack_o` high in the byte's cycle), and the next data byte lands in the register it names.
- R2: A control byte whose pointer field is Dh, Eh or Fh is not acknowledged and leaves pointer and mode unchanged. Every data byte after it, up to the next `txn_begin_i`, is not acknowledged and changes no register.
- R3: Step mode 000, and the reserved modes 001, 010 and 011, never move the pointer, so repeated data bytes overwrite one register.
- R4: Step mode 100 advances the pointer by one after each data byte and wraps from Ch to 0h.
- R5: Step mode 101 wraps from 5h back to 2h.
- R6: Step mode 110 wraps from 7h back to 6h.
- R7: Step mode 111 wraps from 7h back to 2h. In every stepping mode, a pointer at Ch that is not the window's top goes to 0h, so a start at 8h visits 8h..Ch, 0h..7h, then 2h..7h repeatedly.
- R8: `rd_data_o` shows the register under the pointer, and each `rd_req_i` advances the pointer by the same rule as a data write.
- R9: With mode-2 bit 3 at 0, the output registers (indices 2–8) keep their active value until `stop_i`. In the cycle after `stop_i`, every one of them takes its shadow value, including a byte written in the same cycle as `stop_i`.
- R10: With mode-2 bit 3 at 1, an output register's active value changes in the cycle after the acknowledged byte that writes it, with no STOP needed. The bit's new value governs only the bytes that follow the byte that sets it.
- R11: Register map and reset values: 0 mode-1 = 11h, 1 mode-2 = 01h, 2–5 channel duty 0–3 = 00h, 6 group duty = FFh, 7 group frequency = 00h, 8 output select = 00h, 9–11 sub-call addresses = E2h/E4h/E8h, 12 all-call address = E0h.
- R12: Mode-1 bits [7:5] read back the current step mode and ignore writes. Mode-2 bits [7:6] read 0. Bit 0 of registers 9–12 reads 0. Registers 0, 1 and 9–12 take effect in the cycle after the byte that writes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_begin_i | input | 1 | Pulse: transaction (re)started after address match |
| wr_valid_i | input | 1 | Pulse: a received byte is on `wr_byte_i` |
| wr_byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Pulse: the current `rd_data_o` byte is being sent |
| stop_i | input | 1 | Pulse: STOP condition seen |
| byte_ack_o | output | 1 | Acknowledge decision for the byte on `wr_byte_i` |
| rd_data_o | output | 8 | Register under the pointer |
| mode1_o | output | 8 | Mode-1 register including step mode bits |
| mode2_o | output | 8 | Mode-2 register |
| duty_o | output | 32 | Active channel duties, channel 0 in bits [7:0] |
| grp_duty_o | output | 8 | Active group duty |
| grp_freq_o | output | 8 | Active group frequency |
| led_sel_o | output | 8 | Active output select |
| sub1_o | output | 8 | Sub-call address 1 |
| sub2_o | output | 8 | Sub-call address 2 |
| sub3_o | output | 8 | Sub-call address 3 |
| allcall_o | output | 8 | All-call address |

## Verification
A data write and a STOP can land in the same cycle. The commit must then copy the incoming byte and not the old shadow value. The bench raises `wr_valid_i` and `stop_i` together and expects the new byte on the output in the next cycle. A second case also shares one cycle: a byte that flips the commit bit in mode-2. Its own effect must follow the old setting, while the next output write must follow the new one. The bench writes that bit and then an output register, and compares both against a behavioural model on every clock.

// File: rtl/ledcfg_pkg.sv
package ledcfg_pkg;

  localparam int DW    = 8;
  localparam int PW    = 4;
  localparam int NREG  = 13;
  localparam int LAST  = NREG - 1;

  localparam int A_MODE1 = 0;
  localparam int A_MODE2 = 1;
  localparam int A_DUTY0 = 2;
  localparam int NDUTY   = 4;
  localparam int A_GDUTY = A_DUTY0 + NDUTY;
  localparam int A_GFREQ = A_GDUTY + 1;
  localparam int A_OSEL  = A_GFREQ + 1;
  localparam int A_SUB1  = A_OSEL + 1;
  localparam int NSUB    = 3;
  localparam int A_ALLC  = A_SUB1 + NSUB;

  localparam int COMMIT_LO = A_DUTY0;
  localparam int NCOMMIT   = A_OSEL - A_DUTY0 + 1;
  localparam int OCH_BIT   = 3;

  localparam logic [2:0] AI_ALL   = 3'b100;
  localparam logic [2:0] AI_DUTY  = 3'b101;
  localparam logic [2:0] AI_GROUP = 3'b110;
  localparam logic [2:0] AI_MIX   = 3'b111;

  function automatic logic [7:0] reg_reset(input int idx);
    case (idx)
      A_MODE1:    return 8'h11;
      A_MODE2:    return 8'h01;
      A_GDUTY:    return 8'hFF;
      A_SUB1:     return 8'hE2;
      A_SUB1 + 1: return 8'hE4;
      A_SUB1 + 2: return 8'hE8;
      A_ALLC:     return 8'hE0;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int idx);
    if (idx == A_MODE1) return 8'h1F;
    if (idx == A_MODE2) return 8'h3F;
    if (idx >= A_SUB1)  return 8'hFE;
    return 8'hFF;
  endfunction

endpackage

// File: rtl/ledcfg_pointer.sv
module ledcfg_pointer
  import ledcfg_pkg::*;
#(
  parameter int PTR_W = PW,
  parameter int N_REG = NREG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_begin_i,
  input  logic             wr_valid_i,
  input  logic [PTR_W-1:0] ctl_ptr_i,
  input  logic [2:0]       ctl_mode_i,
  input  logic             rd_req_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [2:0]       ai_mode_o,
  output logic             data_wr_o,
  output logic             byte_ack_o
);

  localparam logic [PTR_W-1:0] TOP    = PTR_W'(N_REG - 1);
  localparam logic [PTR_W-1:0] ZERO   = '0;
  localparam logic [PTR_W-1:0] DUT_LO = PTR_W'(A_DUTY0);
  localparam logic [PTR_W-1:0] DUT_HI = PTR_W'(A_DUTY0 + NDUTY - 1);
  localparam logic [PTR_W-1:0] GRP_LO = PTR_W'(A_GDUTY);
  localparam logic [PTR_W-1:0] GRP_HI = PTR_W'(A_GFREQ);

  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_step;
  logic [PTR_W-1:0] win_lo, win_hi;
  logic [2:0]       mode_q, mode_d;
  logic             ctl_q, ctl_d;
  logic             dead_q, dead_d;
  logic             step_en, ctl_take, ctl_drop, data_wr;

  // wrap window selected by the step mode
  always_comb begin
    step_en = 1'b1;
    win_lo  = ZERO;
    win_hi  = TOP;
    case (mode_q)
      AI_ALL:   begin win_lo = ZERO;   win_hi = TOP;    end
      AI_DUTY:  begin win_lo = DUT_LO; win_hi = DUT_HI; end
      AI_GROUP: begin win_lo = GRP_LO; win_hi = GRP_HI; end
      AI_MIX:   begin win_lo = DUT_LO; win_hi = GRP_HI; end
      default:  step_en = 1'b0;
    endcase
  end

  always_comb begin
    if (!step_en)            ptr_step = ptr_q;
    else if (ptr_q == win_hi) ptr_step = win_lo;
    else if (ptr_q == TOP)    ptr_step = ZERO;
    else                      ptr_step = ptr_q + PTR_W'(1);
  end

  always_comb begin
    ctl_take = wr_valid_i && ctl_q && (ctl_ptr_i <= TOP);
    ctl_drop = wr_valid_i && ctl_q && (ctl_ptr_i > TOP);
    data_wr  = wr_valid_i && !ctl_q && !dead_q;

    ptr_d  = ptr_q;
    mode_d = mode_q;
    if (ctl_take) begin
      ptr_d  = ctl_ptr_i;
      mode_d = ctl_mode_i;
    end else if (data_wr || rd_req_i) begin
      ptr_d = ptr_step;
    end

    ctl_d = ctl_q;
    if (wr_valid_i) ctl_d = 1'b0;
    if (txn_begin_i) ctl_d = 1'b1;

    dead_d = dead_q;
    if (ctl_drop) dead_d = 1'b1;
    if (txn_begin_i) dead_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      mode_q <= '0;
      ctl_q  <= 1'b0;
      dead_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      mode_q <= mode_d;
      ctl_q  <= ctl_d;
      dead_q <= dead_d;
    end
  end

  assign ptr_o      = ptr_q;
  assign ai_mode_o  = mode_q;
  assign data_wr_o  = data_wr;
  assign byte_ack_o = ctl_take || data_wr;

  // R2: the pointer never rests on a reserved index
  p_ptr_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= TOP);

  // R2: a refused control byte leaves the pointer alone
  p_nack_keeps_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_drop && !rd_req_i) |=> $stable(ptr_q));

  // R3: non-stepping modes hold the pointer across data bytes
  p_no_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !mode_q[2] && !rd_req_i) |=> $stable(ptr_q));

  // R4: whole-bank walk wraps to zero
  p_all_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && mode_q == AI_ALL && ptr_q == TOP) |=> ptr_q == ZERO);

  // R7: duty+group walk wraps to the first duty register
  p_mix_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && mode_q == AI_MIX && ptr_q == GRP_HI) |=> ptr_q == DUT_LO);

endmodule

// File: rtl/ledcfg_regfile.sv
module ledcfg_regfile
  import ledcfg_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int PTR_W  = PW,
  parameter int N_REG  = NREG
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  logic [PTR_W-1:0]               ptr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [2:0]                     ai_mode_i,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic [DATA_W-1:0]              mode1_o,
  output logic [DATA_W-1:0]              mode2_o,
  output logic [NSUB:0][DATA_W-1:0]      addr_o,
  output logic [NCOMMIT-1:0][DATA_W-1:0] commit_src_o
);

  logic [N_REG-1:0][DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]            mode1_view;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST  = DATA_W'(reg_reset(i));
    localparam logic [DATA_W-1:0] MASK = DATA_W'(reg_wmask(i));
    logic hit;

    always_comb begin
      hit      = wr_en_i && (ptr_i == PTR_W'(i));
      sh_d[i]  = hit ? (wdata_i & MASK) : sh_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[i] <= RST;
      else        sh_q[i] <= sh_d[i];
    end
  end

  // upper mode-1 bits are held at zero by the mask; the step mode is merged in
  assign mode1_view = sh_q[A_MODE1] | {ai_mode_i, {(DATA_W-3){1'b0}}};

  always_comb begin
    rd_data_o = mode1_view;
    for (int i = 1; i < N_REG; i++) begin
      if (ptr_i == PTR_W'(i)) rd_data_o = sh_q[i];
    end
  end

  assign mode1_o      = mode1_view;
  assign mode2_o      = sh_q[A_MODE2];
  assign addr_o       = sh_q[A_ALLC:A_SUB1];
  assign commit_src_o = sh_d[A_OSEL:A_DUTY0];

  // R2: with no accepted data byte, the bank does not move
  p_nack_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(sh_q));

endmodule

// File: rtl/ledcfg_commit.sv
module ledcfg_commit
  import ledcfg_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int PTR_W  = PW,
  parameter int N_OUT  = NCOMMIT,
  parameter int BASE   = COMMIT_LO
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         stop_i,
  input  logic                         och_i,
  input  logic                         wr_en_i,
  input  logic [PTR_W-1:0]             ptr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  input  logic [N_OUT-1:0][DATA_W-1:0] src_i,
  output logic [N_OUT-1:0][DATA_W-1:0] active_o
);

  logic [N_OUT-1:0][DATA_W-1:0] active_q, active_d;

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    localparam logic [DATA_W-1:0] RST = DATA_W'(reg_reset(BASE + i));
    logic ack_hit;

    always_comb begin
      ack_hit = och_i && wr_en_i && (ptr_i == PTR_W'(BASE + i));
      if (stop_i)       active_d[i] = src_i[i];
      else if (ack_hit) active_d[i] = wdata_i;
      else              active_d[i] = active_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q[i] <= RST;
      else        active_q[i] <= active_d[i];
    end
  end

  assign active_o = active_q;

  // R9: outputs only move on STOP or on an acknowledged byte in ACK mode
  p_hold_until_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && !(och_i && wr_en_i)) |=> $stable(active_q));

  // R10: with change-on-ACK and no STOP, a byte outside the output range moves nothing
  p_ack_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && wr_en_i && (ptr_i < PTR_W'(BASE))) |=> $stable(active_q));

endmodule

// File: rtl/ledcfg_bank.sv
module ledcfg_bank
  import ledcfg_pkg::*;
#(
  parameter int DATA_W = DW,
  parameter int PTR_W  = PW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    txn_begin_i,
  input  logic                    wr_valid_i,
  input  logic [DATA_W-1:0]       wr_byte_i,
  input  logic                    rd_req_i,
  input  logic                    stop_i,
  output logic                    byte_ack_o,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [DATA_W-1:0]       mode1_o,
  output logic [DATA_W-1:0]       mode2_o,
  output logic [NDUTY*DATA_W-1:0] duty_o,
  output logic [DATA_W-1:0]       grp_duty_o,
  output logic [DATA_W-1:0]       grp_freq_o,
  output logic [DATA_W-1:0]       led_sel_o,
  output logic [DATA_W-1:0]       sub1_o,
  output logic [DATA_W-1:0]       sub2_o,
  output logic [DATA_W-1:0]       sub3_o,
  output logic [DATA_W-1:0]       allcall_o
);

  logic [1:0]                     rst_pipe_q;
  logic                           rst_sn;
  logic [PTR_W-1:0]               ptr;
  logic [2:0]                     ai_mode;
  logic                           data_wr;
  logic [NSUB:0][DATA_W-1:0]      addr_regs;
  logic [NCOMMIT-1:0][DATA_W-1:0] commit_src;
  logic [NCOMMIT-1:0][DATA_W-1:0] active;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  ledcfg_pointer #(.PTR_W(PTR_W), .N_REG(NREG)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_sn),
    .txn_begin_i (txn_begin_i),
    .wr_valid_i  (wr_valid_i),
    .ctl_ptr_i   (wr_byte_i[PTR_W-1:0]),
    .ctl_mode_i  (wr_byte_i[DATA_W-1:DATA_W-3]),
    .rd_req_i    (rd_req_i),
    .ptr_o       (ptr),
    .ai_mode_o   (ai_mode),
    .data_wr_o   (data_wr),
    .byte_ack_o  (byte_ack_o)
  );

  ledcfg_regfile #(.DATA_W(DATA_W), .PTR_W(PTR_W), .N_REG(NREG)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sn),
    .wr_en_i      (data_wr),
    .ptr_i        (ptr),
    .wdata_i      (wr_byte_i),
    .ai_mode_i    (ai_mode),
    .rd_data_o    (rd_data_o),
    .mode1_o      (mode1_o),
    .mode2_o      (mode2_o),
    .addr_o       (addr_regs),
    .commit_src_o (commit_src)
  );

  ledcfg_commit #(.DATA_W(DATA_W), .PTR_W(PTR_W), .N_OUT(NCOMMIT), .BASE(COMMIT_LO)) u_commit (
    .clk      (clk),
    .rst_n    (rst_sn),
    .stop_i   (stop_i),
    .och_i    (mode2_o[OCH_BIT]),
    .wr_en_i  (data_wr),
    .ptr_i    (ptr),
    .wdata_i  (wr_byte_i),
    .src_i    (commit_src),
    .active_o (active)
  );

  assign duty_o     = active[NDUTY-1:0];
  assign grp_duty_o = active[A_GDUTY-COMMIT_LO];
  assign grp_freq_o = active[A_GFREQ-COMMIT_LO];
  assign led_sel_o  = active[A_OSEL-COMMIT_LO];
  assign sub1_o     = addr_regs[0];
  assign sub2_o     = addr_regs[1];
  assign sub3_o     = addr_regs[2];
  assign allcall_o  = addr_regs[NSUB];

endmodule

// File: tb/ledcfg_bank_test.sv
`timescale 1ns/1ps
module ledcfg_bank_test;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic txn_begin_i = 1'b0, wr_valid_i = 1'b0, rd_req_i = 1'b0, stop_i = 1'b0;
  logic [7:0] wr_byte_i = 8'h00;
  logic byte_ack_o;
  logic [7:0] rd_data_o, mode1_o, mode2_o, grp_duty_o, grp_freq_o, led_sel_o;
  logic [7:0] sub1_o, sub2_o, sub3_o, allcall_o;
  logic [31:0] duty_o;

  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ledcfg_bank uut (.*);

  // ---------------- behavioural reference ----------------
  int m_sh[13];
  int m_act[7];
  int m_ptr, m_mode;
  bit m_ctl, m_dead;

  function automatic int keep_bits(int idx);
    if (idx == 0) return 'h1F;
    if (idx == 1) return 'h3F;
    if (idx >= 9) return 'hFE;
    return 'hFF;
  endfunction

  function automatic int advance(int p, int md);
    int lo, hi;
    case (md)
      4: begin lo = 0; hi = 12; end
      5: begin lo = 2; hi = 5;  end
      6: begin lo = 6; hi = 7;  end
      7: begin lo = 2; hi = 7;  end
      default: return p;
    endcase
    if (p == hi) return lo;
    if (p == 12) return 0;
    return p + 1;
  endfunction

  function automatic int m_view(int p);
    if (p == 0) return (m_mode << 5) | m_sh[0];
    return m_sh[p];
  endfunction

  task automatic model_reset();
    int init[13] = '{'h11, 'h01, 0, 0, 0, 0, 'hFF, 0, 0, 'hE2, 'hE4, 'hE8, 'hE0};
    for (int i = 0; i < 13; i++) m_sh[i] = init[i];
    for (int i = 0; i < 7; i++) m_act[i] = m_sh[i + 2];
    m_ptr = 0; m_mode = 0; m_ctl = 0; m_dead = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int och;
      och = (m_sh[1] >> 3) & 1;
      if (wr_valid_i) begin
        if (m_ctl) begin
          if (wr_byte_i[3:0] <= 12) begin
            m_ptr = wr_byte_i[3:0];
            m_mode = wr_byte_i[7:5];
          end else m_dead = 1;
          m_ctl = 0;
        end else if (!m_dead) begin
          int v;
          v = wr_byte_i & keep_bits(m_ptr);
          m_sh[m_ptr] = v;
          if (och == 1 && m_ptr >= 2 && m_ptr <= 8) m_act[m_ptr - 2] = v;
          m_ptr = advance(m_ptr, m_mode);
        end
      end
      if (rd_req_i) m_ptr = advance(m_ptr, m_mode);
      if (stop_i) for (int i = 0; i < 7; i++) m_act[i] = m_sh[i + 2];
      if (txn_begin_i) begin m_ctl = 1; m_dead = 0; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model every clock, away from the edge
  always @(negedge clk) begin
    #3;
    if (!done) begin
      int ea, dut;
      ea = wr_valid_i && (m_ctl ? (wr_byte_i[3:0] <= 12) : !m_dead);
      chk(byte_ack_o == ea[0], "R2 model ack", byte_ack_o, ea);
      chk(rd_data_o == m_view(m_ptr), "R8 model read", rd_data_o, m_view(m_ptr));
      chk(mode1_o == m_view(0), "R12 model mode1", mode1_o, m_view(0));
      chk(mode2_o == m_sh[1], "R12 model mode2", mode2_o, m_sh[1]);
      dut = m_act[0] | (m_act[1] << 8) | (m_act[2] << 16) | (m_act[3] << 24);
      chk(duty_o == dut, "R9 model duty", duty_o, dut);
      chk(grp_duty_o == m_act[4], "R9 model group duty", grp_duty_o, m_act[4]);
      chk(grp_freq_o == m_act[5], "R9 model group freq", grp_freq_o, m_act[5]);
      chk(led_sel_o == m_act[6], "R9 model select", led_sel_o, m_act[6]);
      chk(sub1_o == m_sh[9] && sub2_o == m_sh[10] && sub3_o == m_sh[11] && allcall_o == m_sh[12],
          "R12 model addresses", {sub3_o, sub2_o, sub1_o}, m_sh[11] << 16 | m_sh[10] << 8 | m_sh[9]);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic begin_txn();
    @(negedge clk); txn_begin_i = 1;
    @(negedge clk); txn_begin_i = 0;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    @(negedge clk); wr_valid_i = 1; wr_byte_i = b;
    #1 ack = byte_ack_o;
    @(negedge clk); wr_valid_i = 0;
    #1;
  endtask

  task automatic put_byte_stop(input logic [7:0] b);
    @(negedge clk); wr_valid_i = 1; wr_byte_i = b; stop_i = 1;
    @(negedge clk); wr_valid_i = 0; stop_i = 0;
    #1;
  endtask

  task automatic get_byte(output logic [7:0] d);
    @(negedge clk); rd_req_i = 1;
    #1 d = rd_data_o;
    @(negedge clk); rd_req_i = 0;
    #1;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    #1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic a;
    logic [7:0] d;
    logic [7:0] exp_rd[15] = '{8'h00, 8'hE2, 8'hE4, 8'hF0, 8'hC2, 8'hFF, 8'h01,
                               8'h03, 8'h04, 8'h01, 8'h02, 8'h77, 8'h66, 8'h03, 8'h04};
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    #1;

    // R11 reset values
    chk(mode1_o == 8'h11 && mode2_o == 8'h01, "R11 mode regs", {mode1_o, mode2_o}, 16'h1101);
    chk(duty_o == 0 && grp_duty_o == 8'hFF && grp_freq_o == 0 && led_sel_o == 0,
        "R11 output regs", {grp_duty_o, duty_o[7:0]}, 16'hFF00);
    chk(sub1_o == 8'hE2 && sub2_o == 8'hE4 && sub3_o == 8'hE8 && allcall_o == 8'hE0,
        "R11 address regs", {sub1_o, sub2_o, sub3_o, allcall_o}, 32'hE2E4E8E0);

    // R1 control byte with bit 4 set, whole-bank walk over duties; R9 commit at STOP
    begin_txn();
    put_byte(8'h92, a);
    chk(a == 1, "R1 control ack", a, 1);
    put_byte(8'h10, a); put_byte(8'h20, a); put_byte(8'h30, a); put_byte(8'h40, a);
    chk(duty_o == 32'h0, "R9 held before STOP", duty_o, 0);
    send_stop();
    chk(duty_o == 32'h40302010, "R9 committed at STOP", duty_o, 32'h40302010);

    // R2 reserved pointer refused
    begin_txn();
    put_byte(8'h8E, a);
    chk(a == 0, "R2 reserved pointer nack", a, 0);
    put_byte(8'h55, a);
    chk(a == 0, "R2 data after refusal nack", a, 0);
    send_stop();
    chk(duty_o == 32'h40302010, "R2 nothing written", duty_o, 32'h40302010);

    // R3 no increment and reserved mode
    begin_txn();
    put_byte(8'h03, a); put_byte(8'h11, a); put_byte(8'h22, a);
    begin_txn();
    put_byte(8'h24, a); put_byte(8'h33, a); put_byte(8'h44, a);
    send_stop();
    chk(duty_o == 32'h40442210, "R3 same register overwritten", duty_o, 32'h40442210);

    // R4 wrap C->0 with read-only bits R12
    begin_txn();
    put_byte(8'h8B, a); put_byte(8'hF1, a); put_byte(8'hC3, a); put_byte(8'hFF, a);
    send_stop();
    chk(sub3_o == 8'hF0, "R12 sub-call bit 0 reads 0", sub3_o, 8'hF0);
    chk(allcall_o == 8'hC2, "R4 walk reached register 12", allcall_o, 8'hC2);
    chk(mode1_o == 8'h9F, "R4 wrap to mode-1, R12 step bits read back", mode1_o, 8'h9F);

    // R5 duty window
    begin_txn();
    put_byte(8'hA4, a); put_byte(8'h01, a); put_byte(8'h02, a); put_byte(8'h03, a); put_byte(8'h04, a);
    send_stop();
    chk(duty_o == 32'h02010403, "R5 wrap 5->2", duty_o, 32'h02010403);

    // R6 group window
    begin_txn();
    put_byte(8'hC6, a); put_byte(8'h55, a); put_byte(8'h66, a); put_byte(8'h77, a);
    send_stop();
    chk(grp_duty_o == 8'h77 && grp_freq_o == 8'h66, "R6 wrap 7->6",
        {grp_duty_o, grp_freq_o}, 16'h7766);

    // R7 / R8 read walk from 8h in mode 111
    begin_txn();
    put_byte(8'hE8, a);
    begin_txn();
    for (int i = 0; i < 15; i++) begin
      get_byte(d);
      chk(d == exp_rd[i], "R7 R8 read order", d, exp_rd[i]);
    end
    send_stop();

    // R10 change on ACK
    begin_txn();
    put_byte(8'h01, a); put_byte(8'h09, a);
    chk(mode2_o == 8'h09, "R12 mode-2 immediate", mode2_o, 8'h09);
    begin_txn();
    put_byte(8'h88, a); put_byte(8'hE4, a);
    chk(led_sel_o == 8'hE4, "R10 output follows ACK", led_sel_o, 8'hE4);
    send_stop();

    // R9 write and STOP in the same cycle
    begin_txn();
    put_byte(8'h01, a); put_byte(8'h00, a);
    begin_txn();
    put_byte(8'h07, a);
    put_byte_stop(8'h99);
    chk(grp_freq_o == 8'h99, "R9 STOP with same-cycle byte", grp_freq_o, 8'h99);

    // R12 mode-2 reserved bits
    begin_txn();
    put_byte(8'h01, a); put_byte(8'hFF, a);
    chk(mode2_o == 8'h3F, "R12 mode-2 top bits read 0", mode2_o, 8'h3F);
    send_stop();

    repeat (3) @(negedge clk);
    #4;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule